// File: doc/BRIEF.md
# Streaming Internet Checksum Inserter

This block is an in-line stage on a 64-bit word stream. Each word carries four framing flags: frame start, frame end, part start and part end. A valid/ready handshake runs on both sides. The first frame after reset is a configuration frame. Any word in it that opens a part and carries the tag 9 in its top byte sets up the block. Every frame after that one is a packet. For each packet the block computes a 16-bit Internet checksum over a chosen byte range, and it can add an IPv4 pseudo-header to the sum. It then writes the result back into the same packet at a chosen byte position.

Two state machines share the work. The compute side watches the input and never alters it. It keeps the settings and adds up the bytes of each packet as they arrive. The insert side drains a buffer that holds a full-size frame. It stops at the word that holds the checksum position and waits there until the compute side has seen the end of that packet. Because the buffer absorbs this wait, the checksum can sit ahead of the bytes it covers. Once the pipeline has filled, the line rate stays the same.

Top module: `csum_inserter`

## Requirements
- R1: A word that has the part-start flag set and holds 9 in data[63:56], seen in the first frame after reset, sets the block up. Its fields are range start in data[55:45], range end in data[44:34], insert position in data[33:23], IP header position in data[22:12] and pseudo-header kind in data[11:10]. Other tags, and a top byte of 9 on a word without the part-start flag, leave the settings untouched.
- R2: Every word, configuration words included, leaves the block in arrival order. Its flags are unchanged, and its data is unchanged except for the two checksum bytes of R6.
- R3: Every frame that follows the end of the configuration frame is a packet. Packet byte n sits in word n/8, and byte 0 of a word is data[63:56] (big-endian lanes). Packets are whole words.
- R4: The checksum is the ones'-complement of the ones'-complement sum of 16-bit words taken over the bytes from start to end inclusive. Words pair up from start, with the first byte of each pair as the high byte. An odd final byte is padded with zero, and bytes past the end of the packet count as zero.
- R5: The bytes at the insert position and the one after it count as zero in the sum.
- R6: The checksum is written high byte first at the insert position and the next byte. A byte of that pair that lies past the end of the packet is not written.
- R7: Kind 1 adds an IPv4 pseudo-header to the sum: the eight address bytes from IP position +12 to +19 paired from +12, the protocol byte at IP position +9 as a low byte, and the length end-start+1.
- R8: Kinds 0, 2 and 3 add no pseudo-header.
- R9: With no tag-9 part in the configuration frame, packets pass unchanged.
- R10: The insert position may lie ahead of every byte in the range, and packets may be up to 190 words (1518-byte frames). The two checksum bytes may fall in two different words.
- R11: While outValid is high and outReady is low, the output word and flags hold steady.
- R12: With outReady held high and equal-length packets arriving back to back, inReady never drops. The last word leaves within a fixed latency of about one packet after the last input.
- R13: During and right after reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | 64 | Input word |
| inSof | input | 1 | Input frame start |
| inEof | input | 1 | Input frame end |
| inSop | input | 1 | Input part start |
| inEop | input | 1 | Input part end |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Block accepts the input word |
| outData | output | 64 | Output word |
| outSof | output | 1 | Output frame start |
| outEof | output | 1 | Output frame end |
| outSop | output | 1 | Output part start |
| outEop | output | 1 | Output part end |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Downstream accepts the output word |

## Verification
The bench sends random packet bytes through several setups. A plain header-style range shows whether the sum and the write-back are right. A kind-1 setup shows whether the pseudo-header terms are added. A kind-2 setup checks that this kind behaves like no pseudo-header. A setup with no tag-9 part checks that packets come through untouched.

Directed cases cover the following:
- An insert position at byte 0 with a range over a maximum-size packet, which separates correct buffering from early release.
- An odd-length range starting at an odd byte with the checksum split across two words, which tests pairing and padding.
- An insert position beyond the packet, which must leave the data alone.
- A decoy word with top byte 9 that does not open a part.

Random output backpressure tests holding under stall. A back-to-back run with a ready sink tests sustained throughput.

// File: rtl/csum_ins_pkg.sv
`timescale 1ns/1ps
package csum_ins_pkg;
  localparam int BUS_W  = 64;
  localparam int LANES  = BUS_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int OFS_W  = 11;
  localparam int POS_W  = OFS_W + 1;
  localparam int WIDX_W = POS_W - LANE_W;
  localparam logic [7:0] CFG_TAG = 8'd9;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_V4   = 2'd1,
    KIND_V6   = 2'd2,
    KIND_RSV  = 2'd3
  } pseudoKind_e;

  typedef struct packed {
    logic [OFS_W-1:0] startOfs;
    logic [OFS_W-1:0] endOfs;
    logic [OFS_W-1:0] valueOfs;
    logic [OFS_W-1:0] ipOfs;
    pseudoKind_e      kind;
  } csumCfg_t;

  localparam int CFG_W = $bits(csumCfg_t);

  // one buffered word: packet marker, flags, data
  typedef struct packed {
    logic             isPkt;
    logic             sof;
    logic             eof;
    logic             sop;
    logic             eop;
    logic [BUS_W-1:0] data;
  } laneWord_t;

  localparam int WORD_W = $bits(laneWord_t);

  // strobes from the compute control to the buffers
  typedef struct packed {
    logic pushWord;
    logic pushSum;
    logic markPkt;
  } ctlStrobe_t;
endpackage

// File: rtl/csum_fifo.sv
`timescale 1ns/1ps
module csum_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/csum_compute.sv
`timescale 1ns/1ps
module csum_compute
  import csum_ins_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             accept,
  input  logic [BUS_W-1:0] inData,
  input  logic             inEof,
  input  logic             inSop,
  output csumCfg_t         cfg,
  output logic             active,
  output logic             genPhase,
  output ctlStrobe_t       strobe,
  output logic [15:0]      sumValue
);
  typedef enum logic {PH_CFG, PH_GEN} phase_e;
  phase_e phase;

  logic [WIDX_W-1:0] wordIdx;
  logic [31:0]       acc, wordSum, total;
  logic [16:0]       fold1;
  logic [15:0]       fold2;
  logic [POS_W-1:0]  startPos, endPos, hiPos, loPos, ipPos, lenTerm;
  logic              pseudoOn;

  assign startPos = POS_W'(cfg.startOfs);
  assign endPos   = POS_W'(cfg.endOfs);
  assign hiPos    = POS_W'(cfg.valueOfs);
  assign loPos    = hiPos + POS_W'(1);
  assign ipPos    = POS_W'(cfg.ipOfs);
  assign lenTerm  = endPos - startPos + POS_W'(1);
  assign pseudoOn = active && (cfg.kind == KIND_V4);
  assign genPhase = (phase == PH_GEN);

  // per-word contribution of the eight byte lanes
  always_comb begin
    wordSum = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [POS_W-1:0] off;
      logic [POS_W-1:0] rel;
      logic [7:0]       b;
      off = {wordIdx, LANE_W'(i)};
      rel = off - ipPos;
      b   = inData[BUS_W-1-8*i -: 8];
      if (off >= startPos && off <= endPos && off != hiPos && off != loPos)
        wordSum = wordSum + ((off[0] == startPos[0]) ? {16'd0, b, 8'd0} : {24'd0, b});
      if (pseudoOn && off >= ipPos) begin
        if (rel >= POS_W'(12) && rel <= POS_W'(19))
          wordSum = wordSum + (rel[0] ? {24'd0, b} : {16'd0, b, 8'd0});
        if (rel == POS_W'(9))
          wordSum = wordSum + {24'd0, b};
      end
    end
  end

  assign total    = acc + wordSum + (pseudoOn ? 32'(lenTerm) : 32'd0);
  assign fold1    = {1'b0, total[15:0]} + {1'b0, total[31:16]};
  assign fold2    = fold1[15:0] + {15'd0, fold1[16]};
  assign sumValue = ~fold2;

  assign strobe.pushWord = accept;
  assign strobe.pushSum  = accept && genPhase && inEof && active;
  assign strobe.markPkt  = genPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CFG;
      cfg     <= '0;
      active  <= 1'b0;
      wordIdx <= '0;
      acc     <= '0;
    end else if (accept) begin
      case (phase)
        PH_CFG: begin
          if (inSop && inData[BUS_W-1 -: 8] == CFG_TAG) begin
            cfg    <= csumCfg_t'(inData[BUS_W-9 -: CFG_W]);
            active <= 1'b1;
          end
          if (inEof) phase <= PH_GEN;
        end
        default: begin
          if (inEof) begin
            wordIdx <= '0;
            acc     <= '0;
          end else begin
            wordIdx <= wordIdx + WIDX_W'(1);
            acc     <= acc + wordSum;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/csum_insert.sv
`timescale 1ns/1ps
module csum_insert
  import csum_ins_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneWord_t        head,
  input  logic             headValid,
  input  logic [15:0]      sumHead,
  input  logic             sumValid,
  input  logic [OFS_W-1:0] valueOfs,
  input  logic             active,
  input  logic             outReady,
  output logic [BUS_W-1:0] outData,
  output logic [3:0]       outFlags,
  output logic             outValid,
  output logic             popWord,
  output logic             popSum
);
  logic [WIDX_W-1:0] wordIdx;
  logic [POS_W-1:0]  hiPos, loPos;
  logic              own, touch, needSum;

  assign hiPos   = POS_W'(valueOfs);
  assign loPos   = hiPos + POS_W'(1);
  assign own     = head.isPkt && active;
  assign touch   = (wordIdx == hiPos[POS_W-1:LANE_W]) || (wordIdx == loPos[POS_W-1:LANE_W]);
  assign needSum = own && (touch || head.eof);

  assign outValid = headValid && (!needSum || sumValid);
  assign popWord  = outValid && outReady;
  assign popSum   = popWord && own && head.eof;
  assign outFlags = {head.sof, head.eof, head.sop, head.eop};

  always_comb begin
    outData = head.data;
    for (int i = 0; i < LANES; i++) begin
      logic [POS_W-1:0] off;
      off = {wordIdx, LANE_W'(i)};
      if (own && off == hiPos) outData[BUS_W-1-8*i -: 8] = sumHead[15:8];
      if (own && off == loPos) outData[BUS_W-1-8*i -: 8] = sumHead[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordIdx <= '0;
    else if (popWord && head.isPkt) wordIdx <= head.eof ? '0 : wordIdx + WIDX_W'(1);
  end
endmodule

// File: rtl/csum_inserter.sv
`timescale 1ns/1ps
module csum_inserter
  import csum_ins_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int SUM_DEPTH  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] inData,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        inSop,
  input  logic        inEop,
  input  logic        inValid,
  output logic        inReady,
  output logic [63:0] outData,
  output logic        outSof,
  output logic        outEof,
  output logic        outSop,
  output logic        outEop,
  output logic        outValid,
  input  logic        outReady
);
  localparam int DCW = $clog2(FIFO_DEPTH + 1);
  localparam int SCW = $clog2(SUM_DEPTH + 1);

  csumCfg_t   cfg;
  ctlStrobe_t strobe;
  laneWord_t  wrWord, headWord;
  logic       active, genPhase, accept;
  logic       dataEmpty, dataFull, sumEmpty, sumFull, popWord, popSum;
  logic [15:0] sumValue, sumHead;
  logic [3:0]  outFlags;
  logic [DCW-1:0] dataCount;
  logic [SCW-1:0] sumCount;

  assign inReady = !dataFull && !sumFull;
  assign accept  = inValid && inReady;
  assign wrWord  = '{isPkt: strobe.markPkt, sof: inSof, eof: inEof, sop: inSop, eop: inEop, data: inData};

  csum_compute u_compute (
    .clk(clk), .rstN(rstN), .accept(accept), .inData(inData), .inEof(inEof), .inSop(inSop),
    .cfg(cfg), .active(active), .genPhase(genPhase), .strobe(strobe), .sumValue(sumValue)
  );

  csum_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_dataFifo (
    .clk(clk), .rstN(rstN), .push(strobe.pushWord), .wrData(wrWord), .pop(popWord),
    .rdData(headWord), .empty(dataEmpty), .full(dataFull), .count(dataCount)
  );

  csum_fifo #(.WIDTH(16), .DEPTH(SUM_DEPTH)) u_sumFifo (
    .clk(clk), .rstN(rstN), .push(strobe.pushSum), .wrData(sumValue), .pop(popSum),
    .rdData(sumHead), .empty(sumEmpty), .full(sumFull), .count(sumCount)
  );

  csum_insert u_insert (
    .clk(clk), .rstN(rstN), .head(headWord), .headValid(!dataEmpty), .sumHead(sumHead),
    .sumValid(!sumEmpty), .valueOfs(cfg.valueOfs), .active(active), .outReady(outReady),
    .outData(outData), .outFlags(outFlags), .outValid(outValid), .popWord(popWord), .popSum(popSum)
  );

  assign {outSof, outEof, outSop, outEop} = outFlags;
endmodule

// File: rtl/csum_ins_chk.sv
`timescale 1ns/1ps
module csum_ins_chk
  import csum_ins_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int SUM_DEPTH  = 4,
  parameter int DCW = 9,
  parameter int SCW = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           outValid,
  input logic           outReady,
  input logic [63:0]    outData,
  input logic [3:0]     outFlags,
  input logic [DCW-1:0] dataCount,
  input logic [SCW-1:0] sumCount,
  input logic           genPhase,
  input csumCfg_t       cfg
);
  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outFlags));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    dataCount <= DCW'(FIFO_DEPTH));

  p_sum_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    sumCount <= SCW'(SUM_DEPTH));

  p_gen_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    genPhase |=> genPhase);

  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rstN)
    genPhase && $past(genPhase) |-> $stable(cfg));
endmodule

bind csum_inserter csum_ins_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .SUM_DEPTH(SUM_DEPTH), .DCW(DCW), .SCW(SCW)
) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady), .outData(outData),
  .outFlags({outSof, outEof, outSop, outEop}), .dataCount(dataCount), .sumCount(sumCount),
  .genPhase(genPhase), .cfg(cfg)
);

// File: tb/sim_csum_inserter.sv
`timescale 1ns/1ps
module sim_csum_inserter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic [63:0] inData = '0, outData;
  logic inSof = 0, inEof = 0, inSop = 0, inEop = 0, inValid = 0, inReady;
  logic outSof, outEof, outSop, outEop, outValid;
  logic outReady = 0;

  csum_inserter u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inSof(inSof), .inEof(inEof), .inSop(inSop),
    .inEop(inEop), .inValid(inValid), .inReady(inReady), .outData(outData), .outSof(outSof),
    .outEof(outEof), .outSop(outSop), .outEop(outEop), .outValid(outValid), .outReady(outReady)
  );

  int checks = 0, fails = 0, stalls = 0, cyc = 0, lastOutCyc = 0;
  bit done = 0, fastReady = 0, countStalls = 0;
  logic [67:0] expQ[$];
  string tagQ[$];
  int cStart, cEnd, cVal, cIp, cKind;
  bit cActive;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // output sink and comparison
  initial begin
    forever begin : sink
      logic [67:0] got, want;
      string t;
      @(negedge clk);
      outReady = fastReady ? 1'b1 : (($urandom % 4) != 0);
      if (rstN && outValid && outReady) begin
        got = {outSof, outEof, outSop, outEop, outData};
        lastOutCyc = cyc;
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 extra output word act=%h exp=none", got);
        end else begin
          want = expQ.pop_front();
          t = tagQ.pop_front();
          check(got === want, t, "output word", got, want);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  task automatic sendWord(input logic [63:0] d, input logic s, input logic e,
                          input logic sp, input logic ep);
    bit r;
    inData = d; inSof = s; inEof = e; inSop = sp; inEop = ep; inValid = 1'b1;
    do begin
      r = inReady;
      if (!r && countStalls) stalls++;
      @(posedge clk); #1;
    end while (!r);
    inValid = 1'b0;
  endtask

  task automatic pushExp(input logic [63:0] d, input logic s, input logic e,
                         input logic sp, input logic ep, input string tag);
    expQ.push_back({s, e, sp, ep, d});
    tagQ.push_back(tag);
  endtask

  task automatic resetDut();
    rstN = 1'b0; inValid = 1'b0;
    expQ.delete(); tagQ.delete();
    repeat (3) @(posedge clk); #1;
    check(outValid === 1'b0 && inReady === 1'b1, "R13", "reset state {outValid,inReady}",
          68'({outValid, inReady}), 68'b01);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(outValid === 1'b0 && inReady === 1'b1, "R13", "after release {outValid,inReady}",
          68'({outValid, inReady}), 68'b01);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // configuration frame: decoy part, setup part (or other tag), two-word part whose
  // second word carries top byte 9 without part start (R1)
  task automatic sendCfg(input bit withPart, input int s, input int e, input int v,
                         input int ip, input int k);
    logic [63:0] w [4];
    logic [3:0]  f [4];
    cStart = s; cEnd = e; cVal = v; cIp = ip; cKind = k; cActive = withPart;
    w[0] = {8'd8, rnd64()[55:0]};
    w[1] = {(withPart ? 8'd9 : 8'd11), 11'(s), 11'(e), 11'(v), 11'(ip), 2'(k), 10'd0};
    w[2] = {8'd12, rnd64()[55:0]};
    w[3] = {8'd9, rnd64()[55:0]};
    f[0] = 4'b1011; f[1] = 4'b0011; f[2] = 4'b0010; f[3] = 4'b0101;
    for (int i = 0; i < 4; i++) pushExp(w[i], f[i][3], f[i][2], f[i][1], f[i][0], "R1 R2");
    for (int i = 0; i < 4; i++) sendWord(w[i], f[i][3], f[i][2], f[i][1], f[i][0]);
  endtask

  function automatic logic [15:0] refSum(input logic [7:0] p[]);
    longint unsigned acc = 0;
    int len = p.size();
    for (int o = cStart; o <= cEnd; o++) begin
      longint unsigned b = (o < len) ? longint'(p[o]) : 0;
      if (o == cVal || o == cVal + 1) continue;
      acc += (((o - cStart) % 2) == 0) ? (b << 8) : b;
    end
    if (cKind == 1) begin
      for (int k = 0; k < 8; k++) begin
        int o = cIp + 12 + k;
        longint unsigned b = (o < len) ? longint'(p[o]) : 0;
        acc += ((k % 2) == 0) ? (b << 8) : b;
      end
      if (cIp + 9 < len) acc += longint'(p[cIp + 9]);
      acc += longint'(cEnd - cStart + 1);
    end
    while ((acc >> 16) != 0) acc = (acc & 64'hFFFF) + (acc >> 16);
    return ~acc[15:0];
  endfunction

  task automatic sendPkt(input int nWords, input string tag);
    logic [7:0] p[];
    logic [7:0] q[];
    logic [15:0] cs;
    p = new[nWords * 8];
    foreach (p[i]) p[i] = 8'($urandom);
    q = p;
    if (cActive) begin
      cs = refSum(p);
      if (cVal < p.size()) q[cVal] = cs[15:8];
      if (cVal + 1 < p.size()) q[cVal + 1] = cs[7:0];
    end
    for (int w = 0; w < nWords; w++) begin
      logic [63:0] d = '0;
      for (int i = 0; i < 8; i++) d[63-8*i -: 8] = q[w*8 + i];
      pushExp(d, w == 0, w == nWords - 1, w == 0, w == nWords - 1, tag);
    end
    for (int w = 0; w < nWords; w++) begin
      logic [63:0] d = '0;
      for (int i = 0; i < 8; i++) d[63-8*i -: 8] = p[w*8 + i];
      sendWord(d, w == 0, w == nWords - 1, w == 0, w == nWords - 1);
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    repeat (8) @(posedge clk);
    #1;
  endtask

  initial begin
    int t0;
    void'($urandom(32'd20240611));

    // R9 with R2: no setup part, packets pass unchanged
    resetDut();
    sendCfg(1'b0, 14, 33, 24, 0, 0);
    for (int n = 0; n < 5; n++) sendPkt(2 + ($urandom % 40), "R9 R2");
    drain();

    // R1 R3 R4 R5 R6 R11: header-style range, random backpressure
    resetDut();
    sendCfg(1'b1, 14, 33, 24, 0, 0);
    for (int n = 0; n < 8; n++) sendPkt(5 + ($urandom % 20), "R1 R3 R4 R5 R6 R11");
    drain();

    // R7: IPv4 pseudo-header over a transport range
    resetDut();
    sendCfg(1'b1, 34, 63, 40, 14, 1);
    for (int n = 0; n < 6; n++) sendPkt(8, "R7");
    sendPkt(6, "R7");
    drain();

    // R8: kind 2 behaves as no pseudo-header
    resetDut();
    sendCfg(1'b1, 34, 63, 40, 14, 2);
    for (int n = 0; n < 4; n++) sendPkt(8, "R8");
    drain();

    // R10: checksum at byte 0 over a maximum-size packet
    resetDut();
    sendCfg(1'b1, 0, 1517, 0, 0, 0);
    sendPkt(190, "R10");
    sendPkt(9, "R10");
    drain();

    // R4 R5 R10: odd start, odd length, checksum split over words 0 and 1
    resetDut();
    sendCfg(1'b1, 3, 21, 7, 0, 0);
    for (int n = 0; n < 5; n++) sendPkt(3 + ($urandom % 3), "R4 R5 R10");
    drain();

    // R6: insert position beyond the packet leaves data unchanged
    resetDut();
    sendCfg(1'b1, 0, 63, 500, 0, 0);
    for (int n = 0; n < 4; n++) sendPkt(8, "R6");
    drain();

    // R12: back-to-back packets with a ready sink
    resetDut();
    fastReady = 1'b1;
    sendCfg(1'b1, 14, 33, 24, 0, 0);
    stalls = 0; countStalls = 1'b1; t0 = cyc;
    for (int n = 0; n < 10; n++) sendPkt(32, "R12");
    countStalls = 1'b0;
    drain();
    check(stalls == 0, "R12", "input stall cycles", 68'(stalls), 68'd0);
    check((lastOutCyc - t0) <= 10 * 32 + 60, "R12", "cycles to last output",
          68'(lastOutCyc - t0), 68'(10 * 32 + 60));
    fastReady = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule